// File: doc/BRIEF.md
# Stopped-Clock Input Monitor

This block runs on a free-running reference clock and watches a set of monitored clocks, two by default. For each monitored clock it keeps a fault flag. The flag rises when that input has held one level, high or low, for longer than a timeout measured in reference cycles. The default of 20 cycles at 100 MHz gives 200 ns. Every input is watched at all times, whether or not a downstream selector is using it.

A flag that has been raised does not drop on the first sign of life. It drops only after the input has produced a fixed number of synchronized rising edges. If the input stalls again before that count is reached, the count starts over. The flags drive a glitch-free clock selector and an output stage further down the chain. While a stall has begun but the timeout has not yet expired, the flag stays low, and downstream logic must wait for it.

Each input passes through a two-stage synchronizer and then an edge register. A flag therefore moves three reference cycles after the input event that causes it.

Top module: `clk_loss_monitor`

## Requirements
- R1: While reset is asserted, and directly after it is released, every bit of `bad_o` is 1 (fault).
- R2: Bit i of `bad_o` depends only on `mon_clk_i[i]`. A stalled input never changes the flag of an input that is toggling.
- R3: If an input last changed level in the reference cycle in which it was sampled at c, and then holds that level (high or low), its flag is 1 from cycle c+TIMEOUT_CYC+3 onward.
- R4: While an input changes level at intervals of at most TIMEOUT_CYC reference cycles, a clear flag stays 0. A half-period of exactly TIMEOUT_CYC never raises it.
- R5: A raised flag returns to 0 three reference cycles after the RECOVER_PERIODS-th rising edge (0 to 1) of that input, counted since the flag was raised. Falling edges do not count.
- R6: If a timeout expires again while a flag is raised and recovery is partway through, the rising-edge count restarts from zero and a full RECOVER_PERIODS edges are needed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_ref |
| mon_clk_i | input | NUM_IN | Monitored clocks, asynchronous to clk_ref |
| bad_o | output | NUM_IN | Per-input fault flag, 1 = stopped or not yet recovered |

## Verification
The in-design assertions rely on one assumption: each monitored input reaches the edge register only through its synchronizer, so a level change shows up as a single-cycle change pulse in the reference domain. The stimulus changes monitored inputs only on the falling edge of the reference clock and at most once per reference cycle, so that every transition is seen as exactly one pulse. Half-periods are chosen on both sides of the timeout, at TIMEOUT_CYC and at TIMEOUT_CYC+1. Stalls are placed both at high and at low levels, and partway through a recovery.

// File: rtl/clm_pkg.sv
package clm_pkg;

    // Per-input event information in the reference domain
    typedef struct packed {
        logic level;   // synchronized level of the monitored clock
        logic change;  // level differs from the previous reference cycle
        logic rise;    // 0 -> 1 transition seen this cycle
    } edge_info_t;

endpackage

// File: rtl/clm_sync.sv
module clm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/clm_edge.sv
module clm_edge
    import clm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    output edge_info_t info_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d        = level_i;
        info_o.level  = level_i;
        info_o.change = level_i ^ prev_q;
        info_o.rise   = level_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/clm_channel.sv
module clm_channel
    import clm_pkg::*;
#(
    parameter int TIMEOUT_CYC     = 20,
    parameter int RECOVER_PERIODS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  edge_info_t ev_i,
    output logic       bad_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam int RW = $clog2(RECOVER_PERIODS + 1);
    localparam logic [TW-1:0] T_LIM  = TW'(TIMEOUT_CYC);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);
    localparam logic [RW-1:0] R_LIM  = RW'(RECOVER_PERIODS);
    localparam logic [RW-1:0] R_LAST = RW'(RECOVER_PERIODS - 1);

    typedef struct packed {
        logic [TW-1:0] timer;  // cycles since last level change, saturating
        logic [RW-1:0] rec;    // rising edges seen while flagged
        logic          bad;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      timeout_hit;

    always_comb begin
        st_d        = st_q;
        timeout_hit = !ev_i.change && (st_q.timer == T_LAST);

        if (ev_i.change)          st_d.timer = '0;
        else if (st_q.timer != T_LIM) st_d.timer = st_q.timer + 1'b1;

        if (timeout_hit) begin
            st_d.bad = 1'b1;
            st_d.rec = '0;
        end else if (st_q.bad && ev_i.rise) begin
            if (st_q.rec == R_LAST) begin
                st_d.bad = 1'b0;
                st_d.rec = '0;
            end else begin
                st_d.rec = st_q.rec + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.timer <= '0;
            st_q.rec   <= '0;
            st_q.bad   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bad_o = st_q.bad;

    // R3: a saturated timer means the input is flagged
    a_r3_saturated_is_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.timer == T_LIM) |-> st_q.bad);

    // R4: a flag only rises after a full silent window
    a_r4_rise_needs_silence: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.bad) |-> ($past(st_q.timer) == T_LAST));

    // R5: a flag only drops on a synchronized rising edge
    a_r5_clear_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.bad) |-> $past(ev_i.rise));

    // R6: recovery count stays in range and is idle when good
    a_r6_rec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rec < R_LIM);
    a_r6_rec_idle_when_good: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.bad |-> (st_q.rec == '0));
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor
    import clm_pkg::*;
#(
    parameter int NUM_IN          = 2,
    parameter int TIMEOUT_CYC     = 20,
    parameter int RECOVER_PERIODS = 4,
    parameter int SYNC_STAGES     = 2
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] mon_clk_i,
    output logic [NUM_IN-1:0] bad_o
);
    logic       [NUM_IN-1:0] level_s;
    edge_info_t              ev   [NUM_IN];

    generate
        for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
            clm_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk    (clk_ref),
                .rst_n  (rst_n),
                .async_i(mon_clk_i[gi]),
                .sync_o (level_s[gi])
            );
            clm_edge u_edge (
                .clk    (clk_ref),
                .rst_n  (rst_n),
                .level_i(level_s[gi]),
                .info_o (ev[gi])
            );
            clm_channel #(
                .TIMEOUT_CYC    (TIMEOUT_CYC),
                .RECOVER_PERIODS(RECOVER_PERIODS)
            ) u_chan (
                .clk  (clk_ref),
                .rst_n(rst_n),
                .ev_i (ev[gi]),
                .bad_o(bad_o[gi])
            );
        end
    endgenerate

    // R1: flags are all set in the first cycle after reset
    a_r1_reset_bad: assert property (@(posedge clk_ref)
        !rst_n |=> (bad_o == '1));
endmodule

// File: tb/clk_loss_monitor_test.sv
module clk_loss_monitor_test;
    localparam int T  = 20;
    localparam int RP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mon = 2'b00;
    logic [1:0] bad;
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clk_loss_monitor #(.NUM_IN(2), .TIMEOUT_CYC(T), .RECOVER_PERIODS(RP)) uut (
        .clk_ref  (clk_ref_w),
        .rst_n    (rst_n),
        .mon_clk_i(mon),
        .bad_o    (bad)
    );
    wire clk_ref_w = clk;

    typedef struct {
        int    at;
        int    ch;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    // reference model state per channel
    logic m_bad [2];
    int   m_rec [2];
    int   m_last[2];
    logic m_sat [2];
    int   ph    [2];

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: pop and compare items due this cycle
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].at == cyc) begin
                checks++;
                if (bad[sb_q[i].ch] !== sb_q[i].val) begin
                    errors++;
                    $display("FAIL %s ch%0d cycle %0d: actual %b expected %b",
                             sb_q[i].tag, sb_q[i].ch, cyc, bad[sb_q[i].ch], sb_q[i].val);
                end
                sb_q.delete(i);
            end
        end
    end

    // driver: apply one cycle of input and push expected flags
    task automatic drive(input logic [1:0] v);
        string tag;
        @(negedge clk);
        for (int ch = 0; ch < 2; ch++) begin
            if (v[ch] != mon[ch]) begin
                m_last[ch] = cyc;
                m_sat[ch]  = 1'b0;
                if (m_bad[ch] && v[ch]) begin
                    m_rec[ch]++;
                    if (m_rec[ch] == RP) begin
                        m_bad[ch] = 1'b0;
                        m_rec[ch] = 0;
                        tag = "R5 recovery clear";
                    end else tag = "R5 partial recovery";
                end else tag = m_bad[ch] ? "R5 falling edge ignored" : "R4 toggling stays good";
            end else if (!m_sat[ch] && (cyc - m_last[ch] >= T)) begin
                m_sat[ch] = 1'b1;
                tag = (m_bad[ch] && m_rec[ch] > 0) ? "R6 count restart" : "R3 timeout";
                m_bad[ch] = 1'b1;
                m_rec[ch] = 0;
            end else begin
                tag = m_bad[ch] ? "R3 held bad" : "R4 detection window";
            end
            if (ch == 0 && v[1] != mon[1]) tag = {tag, " R2"};
            sb_q.push_back('{at: cyc + 3, ch: ch, val: m_bad[ch], tag: tag});
        end
        mon = v;
    endtask

    // run n cycles with per-channel half-periods (0 = hold level)
    task automatic run(input int n, input int h0, input int h1);
        int hh[2];
        logic [1:0] v;
        hh[0] = h0; hh[1] = h1;
        for (int i = 0; i < n; i++) begin
            v = mon;
            for (int ch = 0; ch < 2; ch++) begin
                if (hh[ch] > 0) begin
                    ph[ch]++;
                    if (ph[ch] >= hh[ch]) begin
                        v[ch] = ~v[ch];
                        ph[ch] = 0;
                    end
                end
            end
            drive(v);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
        summary();
    end

    initial begin
        for (int ch = 0; ch < 2; ch++) begin
            m_bad[ch] = 1'b1; m_rec[ch] = 0; m_sat[ch] = 1'b0; ph[ch] = 0;
        end
        // R1: flags set during reset
        repeat (4) begin
            @(negedge clk);
            checks++;
            if (bad !== 2'b11) begin
                errors++;
                $display("FAIL R1 reset: actual %b expected 11", bad);
            end
        end
        rst_n = 1'b1;
        m_last[0] = cyc - 3;
        m_last[1] = cyc - 3;
        checks++;
        if (bad !== 2'b11) begin
            errors++;
            $display("FAIL R1 after release: actual %b expected 11", bad);
        end
        run(60, 3, 5);    // R5 both recover, R4 stay good
        run(40, 0, 4);    // R3 ch0 stuck low, R2 ch1 unaffected
        run(40, 4, 0);    // R3 ch1 stuck (high or low), ch0 recovers
        run(200, 20, 20); // R4 half-period equal to timeout
        run(200, 20, 21); // R6 ch1 never recovers past timeout
        run(30, 0, 0);    // R3 both stall
        run(11, 2, 2);    // partial recovery
        run(30, 0, 0);    // R6 count restart
        run(20, 2, 2);    // R5 full recovery
        repeat (5) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R5 scoreboard drain: actual %0d expected 0", sb_q.size());
        end
        summary();
    end
endmodule